// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This datapath block sits between a 32-bit data bus and the register file. It turns bus words into register values for loads and register values into bus words for stores, at byte, halfword and word size. On the load side it picks the addressed byte or halfword out of the bus word, moves it to the bottom of the result and fills the upper bits with zeros or with copies of its top bit. On the store side it drives the store data on every byte lane at once. It also produces the byte enables that tell memory which lanes to write.

The store path is always combinational. A parameter chooses the load path: either combinational, or one register stage that adds one cycle of latency and a result-valid flag. The access is described by a strobe, the low address bits, a two-bit size code and a signed flag.

Top module: `ldst_align`

## Requirements
- R1: For a byte load (size code 2'b00) with the signed flag low, the result holds the bus byte at lane `addr[1:0]` (lane n is bits 8n+7:8n) in bits 7:0, and bits 31:8 are zero.
- R2: For a byte load with the signed flag high, bits 31:8 of the result all equal bit 7 of the selected byte.
- R3: For a halfword load (size code 2'b01), `addr[1]` selects the bus halfword (0 selects bits 15:0, 1 selects bits 31:16). That halfword goes to bits 15:0 of the result, and bits 31:16 are zero or sign-copies of its bit 15, as the signed flag selects. `addr[0]` has no effect.
- R4: For a word load (size code 2'b10), the result equals the bus word, whatever the address and the signed flag.
- R5: For a byte store, every byte lane of the bus write word carries bits 7:0 of the register value, and the byte enables are one-hot with bit `addr[1:0]` set.
- R6: For a halfword store, both bus halves carry bits 15:0 of the register value. The enables are 4'b0011 when `addr[1]`=0 and 4'b1100 when `addr[1]`=1. `addr[0]` has no effect.
- R7: For a word store, the bus write word equals the register value and the enables are 4'b1111.
- R8: Size code 2'b11 behaves exactly like a word access on both paths.
- R9: With REG_OUT=1, an access presented at a rising edge gives `rd_valid_o`=1 and its load result on `rd_data_o` after that edge. A cycle without a strobe drops `rd_valid_o` and leaves `rd_data_o` unchanged. Reset clears both outputs to zero.
- R10: With REG_OUT=0, `rd_valid_o` follows `acc_valid_i` and `rd_data_o` shows the load result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 2 | Low address bits of the access |
| acc_size_i | input | 2 | Size code: 00 byte, 01 halfword, 10 or 11 word |
| acc_signed_i | input | 1 | Sign-extend a narrow load when high |
| bus_rdata_i | input | 32 | Word read from the data bus |
| reg_wdata_i | input | 32 | Register value to store |
| rd_valid_o | output | 1 | Load result valid |
| rd_data_o | output | 32 | Right-justified, extended load result |
| bus_wdata_o | output | 32 | Store word, replicated across lanes |
| bus_be_o | output | 4 | Byte-lane write enables |

## Verification
The bench builds two copies at the default 32-bit width. One uses REG_OUT=1 and its load results go through the scoreboard, which lines them up with the one-cycle latency. The other uses REG_OUT=0 and is checked in the same cycle as the access. Together they cover both read-path variants against the same stimulus, including every lane position and sign-boundary data. They also cover the reserved size code and the holding of the last result during idle cycles.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lsa_read_fmt.sv
module lsa_read_fmt
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic [DATA_W-1:0] bus_word_i,
    input  logic [ADDR_W-1:0] lane_i,
    input  logic [1:0]        size_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] value_o
);
    logic [DATA_W-1:0] byte_sh;
    logic [DATA_W-1:0] half_sh;
    logic              fill_b;
    logic              fill_h;

    always_comb begin
        byte_sh = bus_word_i >> {lane_i, 3'b000};
        half_sh = bus_word_i >> {lane_i[ADDR_W-1:1], 4'b0000};
        fill_b  = signed_i & byte_sh[7];
        fill_h  = signed_i & half_sh[15];
        case (acc_size_e'(size_i))
            SZ_BYTE: value_o = {{(DATA_W-8){fill_b}}, byte_sh[7:0]};
            SZ_HALF: value_o = {{(DATA_W-16){fill_h}}, half_sh[15:0]};
            default: value_o = bus_word_i;
        endcase
    end
endmodule

// File: rtl/lsa_write_fmt.sv
module lsa_write_fmt
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic [DATA_W-1:0]   reg_word_i,
    input  logic [ADDR_W-1:0]   lane_i,
    input  logic [1:0]          size_i,
    output logic [DATA_W-1:0]   bus_word_o,
    output logic [DATA_W/8-1:0] be_o
);
    localparam int LANES = DATA_W / 8;

    always_comb begin
        case (acc_size_e'(size_i))
            SZ_BYTE: begin
                bus_word_o = {LANES{reg_word_i[7:0]}};
                be_o       = LANES'(1) << lane_i;
            end
            SZ_HALF: begin
                bus_word_o = {(LANES/2){reg_word_i[15:0]}};
                be_o       = LANES'(2'b11) << {lane_i[ADDR_W-1:1], 1'b0};
            end
            default: begin
                bus_word_o = reg_word_i;
                be_o       = '1;
            end
        endcase
    end
endmodule

// File: rtl/ldst_align.sv
module ldst_align
    import lsa_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_valid_i,
    input  logic [$clog2(DATA_W/8)-1:0]  acc_addr_i,
    input  logic [1:0]                   acc_size_i,
    input  logic                         acc_signed_i,
    input  logic [DATA_W-1:0]            bus_rdata_i,
    input  logic [DATA_W-1:0]            reg_wdata_i,
    output logic                         rd_valid_o,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic [DATA_W-1:0]            bus_wdata_o,
    output logic [DATA_W/8-1:0]          bus_be_o
);
    localparam int LANES  = DATA_W / 8;
    localparam int ADDR_W = $clog2(LANES);

    logic [DATA_W-1:0] fmt_value;

    lsa_read_fmt #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .bus_word_i (bus_rdata_i),
        .lane_i     (acc_addr_i),
        .size_i     (acc_size_i),
        .signed_i   (acc_signed_i),
        .value_o    (fmt_value)
    );

    lsa_write_fmt #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .reg_word_i (reg_wdata_i),
        .lane_i     (acc_addr_i),
        .size_i     (acc_size_i),
        .bus_word_o (bus_wdata_o),
        .be_o       (bus_be_o)
    );

    generate
        if (REG_OUT) begin : g_reg
            typedef struct packed {
                logic              vld;
                logic [DATA_W-1:0] data;
            } rd_stage_t;

            rd_stage_t rd_d, rd_q;

            always_comb begin
                rd_d     = rd_q;
                rd_d.vld = acc_valid_i;
                if (acc_valid_i) begin
                    rd_d.data = fmt_value;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rd_q <= '0;
                end else begin
                    rd_q <= rd_d;
                end
            end

            assign rd_valid_o = rd_q.vld;
            assign rd_data_o  = rd_q.data;

            // R9
            reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                acc_valid_i |=> (rd_valid_o && rd_data_o == $past(fmt_value)));
            // R9
            idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !acc_valid_i |=> (!rd_valid_o && $stable(rd_data_o)));
        end else begin : g_comb
            assign rd_valid_o = acc_valid_i;
            assign rd_data_o  = fmt_value;
        end
    endgenerate

    // R1
    byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i == SZ_BYTE && !acc_signed_i) |-> fmt_value[DATA_W-1:8] == '0);
    // R2
    byte_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i == SZ_BYTE && acc_signed_i) |->
            fmt_value[DATA_W-1:8] == {(DATA_W-8){fmt_value[7]}});
    // R5
    byte_be_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i == SZ_BYTE) |->
            ($countones(bus_be_o) == 1 && bus_wdata_o == {LANES{reg_wdata_i[7:0]}}));
    // R6
    half_be_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i == SZ_HALF) |->
            ($countones(bus_be_o) == 2 && bus_wdata_o == {(LANES/2){reg_wdata_i[15:0]}}));
    // R7
    word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i[1]) |-> (bus_wdata_o == reg_wdata_i && &bus_be_o));
endmodule

// File: tb/ldst_align_bench.sv
`timescale 1ns/1ps
module ldst_align_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic [1:0]  acc_addr_i = '0;
    logic [1:0]  acc_size_i = '0;
    logic        acc_signed_i = 1'b0;
    logic [31:0] bus_rdata_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic        rd_valid_o, c_valid;
    logic [31:0] rd_data_o, c_data;
    logic [31:0] bus_wdata_o, c_wdata;
    logic [3:0]  bus_be_o, c_be;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_rd = '0;

    always #2.5 clk = ~clk;

    ldst_align #(.DATA_W(32), .REG_OUT(1'b1)) u_ldst_align (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
        .acc_size_i(acc_size_i), .acc_signed_i(acc_signed_i), .bus_rdata_i(bus_rdata_i),
        .reg_wdata_i(reg_wdata_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .bus_wdata_o(bus_wdata_o), .bus_be_o(bus_be_o));

    ldst_align #(.DATA_W(32), .REG_OUT(1'b0)) u_ldst_align_comb (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
        .acc_size_i(acc_size_i), .acc_signed_i(acc_signed_i), .bus_rdata_i(bus_rdata_i),
        .reg_wdata_i(reg_wdata_i), .rd_valid_o(c_valid), .rd_data_o(c_data),
        .bus_wdata_o(c_wdata), .bus_be_o(c_be));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(input logic [1:0] a, input logic [1:0] sz,
                                             input logic sg, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[a*8 +: 8];
        h = a[1] ? w[31:16] : w[15:0];
        if (sz == 2'b00) return sg ? {{24{b[7]}}, b} : {24'h0, b};
        if (sz == 2'b01) return sg ? {{16{h[15]}}, h} : {16'h0, h};
        return w;
    endfunction

    function automatic logic [31:0] ref_store(input logic [1:0] sz, input logic [31:0] r);
        if (sz == 2'b00) return {r[7:0], r[7:0], r[7:0], r[7:0]};
        if (sz == 2'b01) return {r[15:0], r[15:0]};
        return r;
    endfunction

    function automatic logic [3:0] ref_be(input logic [1:0] a, input logic [1:0] sz);
        if (sz == 2'b00) begin
            case (a)
                2'd0: return 4'b0001;
                2'd1: return 4'b0010;
                2'd2: return 4'b0100;
                default: return 4'b1000;
            endcase
        end
        if (sz == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    // driver: presents one access, queues the registered expectation,
    // checks the combinational variant and the store path in the same cycle
    task automatic access(input string req, input logic [1:0] a, input logic [1:0] sz,
                          input logic sg, input logic [31:0] w, input logic [31:0] r);
        logic [31:0] e;
        @(posedge clk);
        #1;
        acc_valid_i = 1'b1; acc_addr_i = a; acc_size_i = sz; acc_signed_i = sg;
        bus_rdata_i = w; reg_wdata_i = r;
        e = ref_load(a, sz, sg, w);
        exp_q.push_back(e);
        tag_q.push_back(req);
        last_rd = e;
        #1;
        chk({req, " comb load (R10)"}, c_data, e);
        chk({req, " comb valid (R10)"}, {31'h0, c_valid}, 32'h1);
        chk({req, " store data"}, bus_wdata_o, ref_store(sz, r));
        chk({req, " byte enables"}, {28'h0, bus_be_o}, {28'h0, ref_be(a, sz)});
    endtask

    task automatic idle_check();
        @(posedge clk);
        #1;
        acc_valid_i = 1'b0;
        bus_rdata_i = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        chk("R9 idle valid low", {31'h0, rd_valid_o}, 32'h0);
        chk("R9 idle data held", rd_data_o, last_rd);
        chk("R10 comb valid follows strobe", {31'h0, c_valid}, 32'h0);
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard whenever the registered variant reports a result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk("R9 unexpected valid", rd_data_o, 32'hxxxx_xxxx);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " registered load (R9)"}, rd_data_o, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset valid", {31'h0, rd_valid_o}, 32'h0);
        chk("R9 reset data", rd_data_o, 32'h0);
        rst_n = 1'b1;

        // R1 unsigned bytes at every lane
        for (int i = 0; i < 4; i++)
            access("R1", 2'(i), 2'b00, 1'b0, 32'hF4E3_82A1, 32'h0000_00C5);
        // R2 signed bytes, both sign polarities
        for (int i = 0; i < 4; i++)
            access("R2", 2'(i), 2'b00, 1'b1, 32'h7F80_01FF, 32'h1234_5678);
        // R3 halfwords, addr[0] toggled, both signs
        access("R3", 2'd0, 2'b01, 1'b1, 32'h1234_8001, 32'hAAAA_BEEF);
        access("R3", 2'd1, 2'b01, 1'b1, 32'h1234_8001, 32'hAAAA_BEEF);
        access("R3", 2'd2, 2'b01, 1'b1, 32'h9ABC_7FFF, 32'h0000_7001);
        access("R3", 2'd3, 2'b01, 1'b0, 32'h9ABC_7FFF, 32'h0000_7001);
        access("R6", 2'd3, 2'b01, 1'b0, 32'h0000_0000, 32'hFFFF_00FF);
        // R4 word load ignores address and sign; R7 word store
        access("R4", 2'd3, 2'b10, 1'b1, 32'h8765_4321, 32'hCAFE_F00D);
        access("R7", 2'd1, 2'b10, 1'b0, 32'h0000_0080, 32'h0102_0304);
        // R8 reserved size code acts as word
        access("R8", 2'd2, 2'b11, 1'b1, 32'h8000_00FF, 32'h5A5A_A5A5);
        // R5 byte stores
        access("R5", 2'd2, 2'b00, 1'b0, 32'h0000_0000, 32'hFFFF_FF3C);
        idle_check();

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 scoreboard drained", exp_q.size(), 32'h0);
        wrap_up();
    end
endmodule